// File: doc/BRIEF.md
# SPI Write-Only Register Slave

This block lets an external serial master program the registers of a graphics processor. It listens on three lines: serial clock, serial data and an active-low select. Each line first passes through its own two-flop synchronizer. Everything then runs on the system clock. Rising edges of the serial clock are found by comparing the synchronized value with the value one cycle older.

The bus runs in mode 0. Data is taken on each rising serial-clock edge, most significant bit first. A frame is 32 bits long. The leading byte is the register address and the three bytes after it are the 24-bit data value. When the last bit lands, the block raises a one-cycle write strobe, and its address and data outputs carry the new command.

The select line acts as the write enable. Bits count only while select is held low. A frame that is cut short is thrown away. Once a full frame has been taken, no further bits are accepted until select goes high and then low again. Nothing is ever driven back to the master.

Top module: `spi_regwr_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, the write strobe is low and the address and data outputs read zero.
- R2: For a 32-bit frame sent MSB first, bits 31..24 appear on the address output and bits 23..0 appear on the data output.
- R3: Each complete frame gives exactly one write strobe, and that strobe is high for exactly one system clock.
- R4: The address and data outputs change only in the cycle in which the strobe is high. Otherwise they hold their last values.
- R5: Serial-clock edges that arrive while select is high (inactive) are ignored. They give no strobe and do not advance the bit count of the next frame.
- R6: If select goes high before 32 bits have been taken, the partial frame is discarded with no strobe. The next frame starts again from bit 31.
- R7: Serial-clock edges after the 32nd bit in the same select window are ignored. There is no second strobe, and the outputs keep the first 32 bits.
- R8: If select going high and the 32nd rising serial-clock edge reach the synchronizer outputs in the same cycle, select wins and the frame is discarded with no strobe.
- R9: With the default two synchronizer stages, the strobe is high in the third system cycle after the 32nd serial-clock rise appears at the pin (SYNC_STAGES + 1 clocks).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| sdi_i | input | 1 | Serial data from the master, asynchronous |
| sel_n_i | input | 1 | Select from the master, active low, asynchronous |
| wr_addr_o | output | 8 | Register address of the last complete frame |
| wr_data_o | output | 24 | Data value of the last complete frame |
| wr_valid_o | output | 1 | One-cycle write strobe |

## Verification
Two events can land in the same system cycle: the closing bit of a frame and the loss of select. Both pass through synchronizers of the same depth. The bench therefore moves the serial clock high and the select high in the same time step, so both reach the framer together. The case passes only if no strobe appears and the outputs keep the previous command. A normal frame right afterwards must then decode correctly from its first bit.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;

   localparam int SYNC_MIN = 2;

   typedef enum logic {
      FR_ARMED = 1'b0,
      FR_HOLD  = 1'b1
   } fr_state_t;

endpackage

// File: rtl/spi_regwr_sync.sv
module spi_regwr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_regwr_edge.sv
module spi_regwr_edge (
   input  logic clk,
   input  logic rst,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b0;
      else     prev <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev;
endmodule

// File: rtl/spi_regwr_framer.sv
module spi_regwr_framer
   import spi_regwr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 24,
   localparam int FRAME_W = ADDR_W + DATA_W,
   localparam int CNT_W   = $clog2(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_i,
   input  logic              rise_i,
   input  logic              bit_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   fr_state_t          state;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] shreg_nxt;
   logic [CNT_W-1:0]   cnt;

   assign shreg_nxt = {shreg[FRAME_W-2:0], bit_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= FR_ARMED;
         shreg   <= '0;
         cnt     <= '0;
         valid_o <= 1'b0;
         addr_o  <= '0;
         data_o  <= '0;
      end else begin
         valid_o <= 1'b0;
         if (!sel_i) begin
            state <= FR_ARMED;
            cnt   <= '0;
         end else if (state == FR_ARMED && rise_i) begin
            shreg <= shreg_nxt;
            if (cnt == LAST) begin
               addr_o  <= shreg_nxt[FRAME_W-1 -: ADDR_W];
               data_o  <= shreg_nxt[DATA_W-1:0];
               valid_o <= 1'b1;
               state   <= FR_HOLD;
               cnt     <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign cnt_o = cnt;
endmodule

// File: rtl/spi_regwr_slave.sv
module spi_regwr_slave
   import spi_regwr_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 24,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W = ADDR_W + DATA_W,
   localparam int CNT_W   = $clog2(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic              sel_n_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              wr_valid_o
);
   if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   localparam int        NLINES   = 3;
   localparam logic [2:0] IDLE_LVL = 3'b100;

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] synced;
   logic              sclk_rise;
   logic              sel_active;
   logic [CNT_W-1:0]  bit_cnt;

   assign raw = {sel_n_i, sdi_i, sclk_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_sync
      spi_regwr_sync #(
         .STAGES (SYNC_STAGES),
         .RST_VAL(IDLE_LVL[g])
      ) u_sync (
         .clk(clk),
         .rst(rst),
         .d_i(raw[g]),
         .q_o(synced[g])
      );
   end

   assign sel_active = ~synced[2];

   spi_regwr_edge u_edge (
      .clk   (clk),
      .rst   (rst),
      .lvl_i (synced[0]),
      .rise_o(sclk_rise)
   );

   spi_regwr_framer #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_framer (
      .clk    (clk),
      .rst    (rst),
      .sel_i  (sel_active),
      .rise_i (sclk_rise),
      .bit_i  (synced[1]),
      .addr_o (wr_addr_o),
      .data_o (wr_data_o),
      .valid_o(wr_valid_o),
      .cnt_o  (bit_cnt)
   );
endmodule

// File: rtl/spi_regwr_chk.sv
module spi_regwr_chk #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 24,
   parameter int FRAME_W = 32,
   parameter int CNT_W   = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_valid_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              sel_act,
   input logic              sclk_rise,
   input logic [CNT_W-1:0]  bit_cnt
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!wr_valid_o && wr_addr_o == '0 && wr_data_o == '0));

   p_last_bit_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_valid_o) |-> $past(bit_cnt) == CNT_W'(FRAME_W - 1));

   p_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
      wr_valid_o |=> !wr_valid_o);

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !wr_valid_o |-> ($stable(wr_addr_o) && $stable(wr_data_o)));

   p_sel_gate_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_valid_o) |-> $past(sel_act));

   p_edge_cause_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_valid_o) |-> $past(sclk_rise));
endmodule

bind spi_regwr_slave spi_regwr_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .FRAME_W(FRAME_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_valid_o(wr_valid_o),
   .wr_addr_o (wr_addr_o),
   .wr_data_o (wr_data_o),
   .sel_act   (sel_active),
   .sclk_rise (sclk_rise),
   .bit_cnt   (bit_cnt)
);

// File: tb/spi_regwr_slave_tb.sv
`timescale 1ns/1ps
module spi_regwr_slave_tb;
   localparam int HALF = 6;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        sel_n = 1'b1;
   logic [7:0]  addr;
   logic [23:0] data;
   logic        valid;

   int n_run  = 0;
   int n_fail = 0;
   int pulses = 0;
   int wide   = 0;
   logic prev_valid = 1'b0;

   always #4 clk = ~clk;

   spi_regwr_slave u_dut (
      .clk       (clk),
      .rst       (rst),
      .sclk_i    (sclk),
      .sdi_i     (sdi),
      .sel_n_i   (sel_n),
      .wr_addr_o (addr),
      .wr_data_o (data),
      .wr_valid_o(valid)
   );

   always @(negedge clk) begin
      if (valid) pulses = pulses + 1;
      if (valid && prev_valid) wide = wide + 1;
      prev_valid = valid;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clock_bit(input logic b);
      sdi = b;
      wclk(HALF);
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
   endtask

   task automatic xfer(input logic [39:0] w, input int nbits);
      sel_n = 1'b0;
      wclk(4);
      for (int i = 0; i < nbits; i++) clock_bit(w[39 - i]);
      wclk(4);
      sel_n = 1'b1;
      wclk(8);
   endtask

   task automatic expect_frame(input logic [31:0] w, input string req);
      pulses = 0;
      wide = 0;
      xfer({w, 8'h00}, 32);
      chk(pulses == 1, {req, " R3 pulses"}, pulses, 1);
      chk(wide == 0, {req, " R3 width"}, wide, 0);
      chk(addr == w[31:24], {req, " R2 addr"}, addr, w[31:24]);
      chk(data == w[23:0], {req, " R2 data"}, data, w[23:0]);
   endtask

   task automatic t_reset;
      wclk(2);
      chk(valid == 1'b0, "R1 valid", valid, 0);
      chk(addr == 8'h00, "R1 addr", addr, 0);
      chk(data == 24'h0, "R1 data", data, 0);
      rst = 1'b0;
      wclk(1);
      chk(valid == 1'b0 && addr == 8'h00, "R1 after", {valid, addr}, 0);
   endtask

   task automatic t_basic;
      expect_frame(32'h5A123456, "basic1");
      expect_frame(32'hC3FEDCBA, "basic2");
      expect_frame(32'h00000001, "basic3");
      expect_frame(32'hFF800000, "basic4");
   endtask

   task automatic t_hold;
      expect_frame(32'h3C0F0F0F, "hold");
      wclk(50);
      chk(addr == 8'h3C && data == 24'h0F0F0F, "R4 idle hold", {addr, data}, 32'h3C0F0F0F);
      sel_n = 1'b0;
      wclk(4);
      for (int i = 0; i < 12; i++) clock_bit(i[0]);
      chk(addr == 8'h3C && data == 24'h0F0F0F, "R4 mid-frame hold", {addr, data}, 32'h3C0F0F0F);
      sel_n = 1'b1;
      wclk(8);
   endtask

   task automatic t_unselected;
      pulses = 0;
      for (int i = 0; i < 40; i++) clock_bit(1'b1);
      wclk(6);
      chk(pulses == 0, "R5 no strobe", pulses, 0);
      chk(addr == 8'h3C, "R5 outputs", addr, 8'h3C);
      expect_frame(32'h81A5A5A5, "R5 next");
   endtask

   task automatic t_partial;
      pulses = 0;
      xfer(40'hEE_DDCC_BB00, 20);
      chk(pulses == 0, "R6 no strobe", pulses, 0);
      chk(addr == 8'h81 && data == 24'hA5A5A5, "R6 outputs", {addr, data}, 32'h81A5A5A5);
      expect_frame(32'h7E654321, "R6 restart");
   endtask

   task automatic t_extra;
      pulses = 0;
      xfer(40'h9B_13579B_F0, 40);
      chk(pulses == 1, "R7 single strobe", pulses, 1);
      chk(addr == 8'h9B && data == 24'h13579B, "R7 first bits", {addr, data}, 32'h9B13579B);
      expect_frame(32'h24681357, "R7 rearm");
   endtask

   task automatic t_coincide;
      logic [31:0] w = 32'hA7B8C9DA;
      pulses = 0;
      sel_n = 1'b0;
      wclk(4);
      for (int i = 0; i < 31; i++) clock_bit(w[31 - i]);
      sdi = w[0];
      wclk(HALF);
      sclk = 1'b1;
      sel_n = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
      wclk(8);
      chk(pulses == 0, "R8 select wins", pulses, 0);
      chk(addr == 8'h24 && data == 24'h681357, "R8 outputs", {addr, data}, 32'h24681357);
      expect_frame(32'h13F00D42, "R8 next");
   endtask

   task automatic t_latency;
      logic [31:0] w = 32'h5511AA22;
      int lat = 0;
      sel_n = 1'b0;
      wclk(4);
      for (int i = 0; i < 31; i++) clock_bit(w[31 - i]);
      sdi = w[0];
      wclk(HALF);
      sclk = 1'b1;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (valid && lat == 0) lat = k;
      end
      sclk = 1'b0;
      wclk(4);
      sel_n = 1'b1;
      wclk(8);
      chk(lat == 3, "R9 latency", lat, 3);
      chk(addr == 8'h55 && data == 24'h11AA22, "R9 value", {addr, data}, 32'h5511AA22);
   endtask

   initial begin : watchdog
      #(8ns * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_basic();
      t_hold();
      t_unselected();
      t_partial();
      t_extra();
      t_coincide();
      t_latency();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule